// File: doc/BRIEF.md
# Message-signalled interrupt frame

This block receives doorbell writes on a small 32-bit register port and turns each one into a single-cycle pulse on a bank of shared peripheral interrupt (SPI) lines. The frame decodes a 4 KB window. A bus master writes an interrupt number to the doorbell word, and the frame maps that number onto one line of its bank. Software can read back the range the frame serves from a type word, and the implementation from an identification word.

The range served is fixed at build time by two parameters: the lowest SPI number and the count of lines. Output bit `k` of `spi_o` stands for SPI number `BASE_SPI + k`. A two-bit strap selects how the written value is read. It can be an absolute SPI number, an offset from the base, or the SPI number minus 32. A value that falls outside the served range raises no line and sets a sticky flag instead. Elaboration rejects a configuration whose base is below 32, whose count is zero, or whose base plus count is above 1019.

Top module: `msi_spi_frame`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first access, `spi_o`, `drop_err_o` and `rdata_o` are all zero.
- R2: A read of byte offset 0x008 returns `BASE_SPI` in bits [25:16] and `NUM_SPI` in bits [9:0], with every other bit zero. `rdata_o` takes the value on the clock edge that accepts the read and holds it until the next read.
- R3: A read of byte offset 0xFCC returns the `IDENT` parameter. A write to that offset leaves the value read back unchanged.
- R4: With `map_mode_i` = 2'b00 or 2'b11, writing N to byte offset 0x040 with `BASE_SPI` <= N < `BASE_SPI+NUM_SPI` drives `spi_o[N-BASE_SPI]` high for exactly the one cycle after the write edge. Every other bit stays low. Writes on back-to-back cycles give back-to-back pulses.
- R5: With `map_mode_i` = 2'b01, the doorbell value N selects SPI `N+BASE_SPI`, so N = 0 selects bit 0.
- R6: With `map_mode_i` = 2'b10, the doorbell value N selects SPI `N+32`.
- R7: A doorbell value whose selected SPI lies outside the served range raises no line and sets `drop_err_o` in the following cycle. The flag stays set until reset, and later valid writes still pulse. The selected SPI is computed without wrap-around.
- R8: Reads of offsets other than 0x008 and 0xFCC return zero. Writes to offsets other than 0x040 raise no line and do not set `drop_err_o`.
- R9: Address bits [1:0] are ignored, so any byte address within the doorbell word acts as the doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| map_mode_i | input | 2 | Doorbell value interpretation (00 absolute, 01 base-relative, 10 minus-32, 11 absolute) |
| req_i | input | 1 | Access request, accepted in the same cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte offset within the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| spi_o | output | NUM_SPI | One-cycle interrupt pulses, bit k = SPI BASE_SPI+k |
| drop_err_o | output | 1 | Sticky flag: a doorbell value was out of range |

## Verification
On every cycle, the assertions check four things. At most one line pulses. Any pulse traces back to a doorbell write one cycle earlier. Writes to other offsets raise nothing. The drop flag never clears outside reset. Three behaviours only the bench scenarios can show, by comparing every cycle against a behavioural model. First, the right line pulses for each mapping mode, including the edges of the range and values that would wrap. Second, the type and identification words read back with the correct contents. Third, the ignored writes and the ignored low address bits leave the readable state as it was.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
  typedef enum logic [1:0] {
    MAP_ABS      = 2'b00,
    MAP_REL_BASE = 2'b01,
    MAP_REL_32   = 2'b10,
    MAP_ABS_ALT  = 2'b11
  } map_mode_e;

  localparam int unsigned WORD_W   = 10;
  localparam logic [WORD_W-1:0] W_TYPE  = 10'h002; // byte 0x008
  localparam logic [WORD_W-1:0] W_BELL  = 10'h010; // byte 0x040
  localparam logic [WORD_W-1:0] W_IDENT = 10'h3F3; // byte 0xFCC

  localparam int unsigned SPI_FLOOR = 32;
  localparam int unsigned SPI_CEIL  = 1019;
  localparam int unsigned REL_FIXED = 32;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE_SPI = 64,
  parameter int unsigned NUM_SPI  = 32,
  parameter logic [31:0] IDENT    = 32'h0001_0A5B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bell_o,
  output logic [31:0]       rdata_o
);
  localparam logic [31:0] TYPE_VAL =
    {6'd0, BASE_SPI[9:0], 6'd0, NUM_SPI[9:0]};

  logic        rd_en;
  logic [31:0] rd_mux;

  assign bell_o = req_i && we_i && (word_i == W_BELL);
  assign rd_en  = req_i && !we_i;

  always_comb begin
    unique case (word_i)
      W_TYPE:  rd_mux = TYPE_VAL;
      W_IDENT: rd_mux = IDENT;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  a_r8_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && word_i != W_TYPE && word_i != W_IDENT) |=> (rdata_o == '0));

  a_r2_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_o));
endmodule

// File: rtl/msi_spi_map.sv
module msi_spi_map
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE_SPI = 64,
  parameter int unsigned NUM_SPI  = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [1:0]       mode_i,
  input  logic [31:0]      data_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [32:0] LO  = 33'(BASE_SPI);
  localparam logic [32:0] HI  = 33'(BASE_SPI + NUM_SPI);
  localparam logic [32:0] REL = 33'(REL_FIXED);

  logic [32:0] spi_abs;
  logic [32:0] spi_rel;

  // 33-bit sum so large doorbell values cannot wrap into range
  always_comb begin
    unique case (map_mode_e'(mode_i))
      MAP_REL_BASE: spi_abs = {1'b0, data_i} + LO;
      MAP_REL_32:   spi_abs = {1'b0, data_i} + REL;
      default:      spi_abs = {1'b0, data_i};
    endcase
  end

  assign spi_rel = spi_abs - LO;
  assign hit_o   = (spi_abs >= LO) && (spi_abs < HI);
  assign idx_o   = spi_rel[IDX_W-1:0];
endmodule

// File: rtl/msi_pulse_gen.sv
module msi_pulse_gen #(
  parameter int unsigned NUM_SPI = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               drop_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_SPI-1:0] spi_o,
  output logic               err_o
);
  for (genvar g = 0; g < NUM_SPI; g++) begin : g_line
    logic sel;
    assign sel = fire_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) spi_o[g] <= 1'b0;
      else         spi_o[g] <= sel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= 1'b0;
    else if (drop_i) err_o <= 1'b1;
  end

  a_r4_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(spi_o));

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r7_drop_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i && !fire_i) |=> (spi_o == '0) && err_o);
endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE_SPI = 64,
  parameter int unsigned NUM_SPI  = 32,
  parameter logic [31:0] IDENT    = 32'h0001_0A5B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         map_mode_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [11:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_SPI-1:0] spi_o,
  output logic               drop_err_o
);
  localparam int unsigned IDX_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
  localparam bit CFG_OK = (BASE_SPI >= SPI_FLOOR) && (NUM_SPI != 0) &&
                          (BASE_SPI + NUM_SPI <= SPI_CEIL);

  if (!CFG_OK) begin : g_bad_cfg
    $error("msi_spi_frame: SPI range parameters out of bounds");
  end

  logic [WORD_W-1:0] word;
  logic              bell;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign word = addr_i[11:2];

  msi_reg_decode #(
    .BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .IDENT(IDENT)
  ) u_dec (
    .clk_i, .rst_ni, .req_i, .we_i,
    .word_i (word),
    .bell_o (bell),
    .rdata_o
  );

  msi_spi_map #(
    .BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .IDX_W(IDX_W)
  ) u_map (
    .mode_i (map_mode_i),
    .data_i (wdata_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  msi_pulse_gen #(
    .NUM_SPI(NUM_SPI), .IDX_W(IDX_W)
  ) u_pulse (
    .clk_i, .rst_ni,
    .fire_i (bell && hit),
    .drop_i (bell && !hit),
    .idx_i  (idx),
    .spi_o,
    .err_o  (drop_err_o)
  );

  a_r4_pulse_from_bell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_o != '0) |-> $past(req_i && we_i && addr_i[11:2] == W_BELL));

  a_r8_other_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[11:2] != W_BELL) |=> (spi_o == '0) && ($past(drop_err_o) == drop_err_o));

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (spi_o == '0) && !drop_err_o && (rdata_o == '0));
endmodule

// File: tb/msi_spi_frame_tb_top.sv
module msi_spi_frame_tb_top;
  localparam int unsigned BASE  = 64;
  localparam int unsigned NUM   = 32;
  localparam logic [31:0] IDENT = 32'h0001_0A5B;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic            req = 1'b0, we = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NUM-1:0]  spi;
  logic            err;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  msi_spi_frame #(.BASE_SPI(BASE), .NUM_SPI(NUM), .IDENT(IDENT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .map_mode_i(mode), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .spi_o(spi), .drop_err_o(err));

  // behavioural reference
  logic [NUM-1:0] exp_spi;
  logic           exp_err;
  logic [31:0]    exp_rd;
  longint         sel;
  int             off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_spi <= '0; exp_err <= 1'b0; exp_rd <= '0;
    end else begin
      exp_spi <= '0;
      off = int'(addr) / 4 * 4;
      if (req && we && off == 'h40) begin
        case (mode)
          2'b01:   sel = longint'(wdata) + BASE;
          2'b10:   sel = longint'(wdata) + 32;
          default: sel = longint'(wdata);
        endcase
        if (sel >= BASE && sel < BASE + NUM) exp_spi[int'(sel) - BASE] <= 1'b1;
        else exp_err <= 1'b1;
      end
      if (req && !we) begin
        if (off == 'h008)      exp_rd <= (32'(BASE) << 16) | 32'(NUM);
        else if (off == 'hFCC) exp_rd <= IDENT;
        else                   exp_rd <= '0;
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("spi_o", 64'(spi), 64'(exp_spi));
    chk("drop_err_o", 64'(err), 64'(exp_err));
    chk("rdata_o", 64'(rdata), 64'(exp_rd));
  end

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2);
    tag = "R1";
    chk("reset spi", 64'(spi), 0); chk("reset err", 64'(err), 0); chk("reset rd", 64'(rdata), 0);
    rst_n = 1'b1;
    idle(2);
    chk("post-reset spi", 64'(spi), 0);
    // standard mode
    tag = "R4"; mode = 2'b00;
    acc(1, 12'h040, 64); chk("bit0", 64'(spi), 64'h1);
    idle(1); chk("one cycle", 64'(spi), 0);
    acc(1, 12'h040, 95); chk("bit31", 64'(spi), 64'h8000_0000);
    acc(1, 12'h040, 70); chk("b2b", 64'(spi), 64'h40);
    acc(1, 12'h040, 71); chk("b2b next", 64'(spi), 64'h80);
    mode = 2'b11; acc(1, 12'h040, 80); chk("mode11", 64'(spi), 64'h1_0000);
    idle(1);
    tag = "R2"; acc(0, 12'h008, 0); chk("type", 64'(rdata), 64'h0040_0020);
    idle(2); chk("type held", 64'(rdata), 64'h0040_0020);
    tag = "R3"; acc(0, 12'hFCC, 0); chk("ident", 64'(rdata), 64'(IDENT));
    acc(1, 12'hFCC, 32'hDEAD_BEEF); acc(0, 12'hFCC, 0); chk("ident after write", 64'(rdata), 64'(IDENT));
    tag = "R8";
    acc(1, 12'h008, 70); chk("type write no pulse", 64'(spi), 0); chk("type write no err", 64'(err), 0);
    acc(0, 12'h008, 0); chk("type unchanged", 64'(rdata), 64'h0040_0020);
    acc(1, 12'h100, 70); chk("unmapped write", 64'(spi), 0);
    acc(0, 12'h100, 0); chk("unmapped read", 64'(rdata), 0);
    acc(0, 12'h044, 0); chk("near bell read", 64'(rdata), 0);
    tag = "R9"; mode = 2'b00;
    acc(1, 12'h043, 66); chk("low bits ignored", 64'(spi), 64'h4);
    acc(0, 12'h00B, 0); chk("type via 0x00B", 64'(rdata), 64'h0040_0020);
    tag = "R5"; mode = 2'b01;
    acc(1, 12'h040, 0); chk("rel0", 64'(spi), 64'h1);
    acc(1, 12'h040, 31); chk("rel31", 64'(spi), 64'h8000_0000);
    tag = "R6"; mode = 2'b10;
    acc(1, 12'h040, 32); chk("m32 low", 64'(spi), 64'h1);
    acc(1, 12'h040, 63); chk("m32 high", 64'(spi), 64'h8000_0000);
    idle(1); chk("no err yet", 64'(err), 0);
    tag = "R7";
    acc(1, 12'h040, 31); chk("below drop", 64'(spi), 0); chk("err set", 64'(err), 1);
    mode = 2'b01; acc(1, 12'h040, 32'hFFFF_FFFF); chk("no wrap", 64'(spi), 0);
    mode = 2'b00; acc(1, 12'h040, 96); chk("above drop", 64'(spi), 0);
    acc(1, 12'h040, 63); chk("base-1 drop", 64'(spi), 0);
    acc(1, 12'h040, 65); chk("valid after drop", 64'(spi), 64'h2); chk("err sticky", 64'(err), 1);
    idle(3); chk("err held", 64'(err), 1);
    tag = "R1";
    rst_n = 1'b0; idle(1);
    chk("reset clears err", 64'(err), 0); chk("reset clears rd", 64'(rdata), 0);
    rst_n = 1'b1; idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule